// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds eight one-bit ownership tokens shared by two independent ports, called left and right. Software on either side uses a token to claim a shared resource. Each port has a semaphore select, a write strobe, a 3-bit token index, a write bit and a read bit. A port claims a token by writing a zero to it. It then reads the same token back. A read of zero means the port holds the token. A read of one means it does not.

A claim that is refused is not lost. Each port has a waiting-claim latch for each token. When the holder releases the token by writing a one, a waiting claim from the other port takes ownership at the same clock edge. If both ports claim the same free token in the same cycle, the left port is granted and the right port's claim waits. Writes take effect at the rising clock edge. Reads are combinational and show the state stored before that edge.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-low reset, every token is free and no claim is waiting. A read of any token from either port then returns 1.
- R2: A write with write bit 0 to a free token makes the writing port its holder from the next cycle on.
- R3: A read (select high, write strobe low) returns 0 only when the reading port holds the addressed token. Every other read returns 1, including reads of a free token. The read bit is also 1 whenever select is low or the write strobe is high.
- R4: A claim of a token held by the other port leaves the holder unchanged, and the claiming port reads 1.
- R5: When the holder writes 1 to its token and the other port has no waiting claim, the token becomes free.
- R6: A write of 1 by a port that does not hold the token does not change the holder. That write also cancels the port's own waiting claim on the token.
- R7: When the holder releases a token on which the other port has a waiting claim, the other port becomes the holder in the next cycle. The other port does not have to access the token again.
- R8: When both ports claim the same free token in the same cycle, the left port becomes the holder and the right port's claim waits.
- R9: An access to one token index changes no other token.
- R10: A claim by the port that already holds the token has no effect and leaves no waiting claim behind. A later release by that port frees the token.
- R11: A write strobe with select low has no effect on any token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_wr | input | 1 | Left port write strobe |
| l_idx | input | 3 | Left port token index |
| l_wbit | input | 1 | Left write bit: 0 claims, 1 releases |
| l_rbit | output | 1 | Left read bit: 0 means the left port holds the token |
| r_sel | input | 1 | Right port semaphore select |
| r_wr | input | 1 | Right port write strobe |
| r_idx | input | 3 | Right port token index |
| r_wbit | input | 1 | Right write bit: 0 claims, 1 releases |
| r_rbit | output | 1 | Right read bit: 0 means the right port holds the token |

## Verification
The assertions check the following on every cycle:
- the two ports never both read 0 on the same token;
- a free token always reads 1;
- a claim on a free token grants it, with the left port winning a tie;
- a holder keeps its token until it writes a 1;
- a release takes the token away from the releasing port;
- the reset state.

The waiting-claim latches are not visible at the ports. Their effects show only over sequences of operations, so only the bench scenarios can show them:
- handover to a refused port;
- cancellation by a non-holder's write of 1;
- the absence of a waiting claim after a holder claims again.

The bench compares both read bits against its reference model on every clock.

// File: rtl/sem_pkg.sv
// Package: types shared by the semaphore bank modules.
// Assumes: exactly two ports, left and right.
package sem_pkg;

    // Which port holds a token
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

endpackage

// File: rtl/sem_port_dec.sv
// Module: sem_port_dec
// Decodes one port's access into one-hot claim and release vectors,
// one bit per token.
// Assumes: an access counts only when sel and wr are both high.
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wbit,
    output logic [NUM_FLAGS-1:0] claim_vec,
    output logic [NUM_FLAGS-1:0] free_vec
);

    logic wr_hit;
    assign wr_hit = sel & wr;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        // Purpose: mark token k as claimed (write of 0) or released (write of 1)
        always_comb begin
            claim_vec[k] = wr_hit && (idx == IDX_W'(k)) && !wbit;
            free_vec[k]  = wr_hit && (idx == IDX_W'(k)) &&  wbit;
        end
    end

endmodule

// File: rtl/sem_flag_cell.sv
// Module: sem_flag_cell
// State of one token: held bit, holder side and one waiting-claim latch
// per port.
// Assumes: a port issues at most one of claim or release per cycle.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_l,
    input  logic free_l,
    input  logic claim_r,
    input  logic free_r,
    output logic held,
    output logic owner
);

    logic  held_q, held_d;
    side_e owner_q, owner_d;
    logic  wait_l_q, wait_l_d;
    logic  wait_r_q, wait_r_d;
    logic  own_l, own_r, vacant;
    logic  want_l, want_r;

    // Purpose: work out the holder and the waiting claims for the next cycle
    always_comb begin
        own_l  = held_q && (owner_q == SIDE_LEFT);
        own_r  = held_q && (owner_q == SIDE_RIGHT);
        want_l = free_l ? 1'b0 : ((wait_l_q || claim_l) && !own_l);
        want_r = free_r ? 1'b0 : ((wait_r_q || claim_r) && !own_r);
        vacant = !held_q || (own_l && free_l) || (own_r && free_r);
        held_d   = held_q;
        owner_d  = owner_q;
        wait_l_d = want_l;
        wait_r_d = want_r;
        if (vacant) begin
            if (want_l) begin
                held_d   = 1'b1;
                owner_d  = SIDE_LEFT;
                wait_l_d = 1'b0;
            end else if (want_r) begin
                held_d   = 1'b1;
                owner_d  = SIDE_RIGHT;
                wait_r_d = 1'b0;
            end else begin
                held_d   = 1'b0;
                owner_d  = SIDE_LEFT;
            end
        end
    end

    // Purpose: register the token state, with a synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= 1'b0;
            owner_q  <= SIDE_LEFT;
            wait_l_q <= 1'b0;
            wait_r_q <= 1'b0;
        end else begin
            held_q   <= held_d;
            owner_q  <= owner_d;
            wait_l_q <= wait_l_d;
            wait_r_q <= wait_r_d;
        end
    end

    assign held  = held_q;
    assign owner = owner_q;

endmodule

// File: rtl/sem_read_mux.sv
// Module: sem_read_mux
// Read-back path for one port: returns 0 only when that port holds the
// addressed token.
// Assumes: SIDE is 0 for the left port and 1 for the right port.
module sem_read_mux #(
    parameter int   NUM_FLAGS = 8,
    parameter int   IDX_W     = $clog2(NUM_FLAGS),
    parameter logic SIDE      = 1'b0
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] held_vec,
    input  logic [NUM_FLAGS-1:0] owner_vec,
    output logic                 rbit
);

    // Purpose: drive 0 only for a plain read of a token this side holds
    always_comb begin
        rbit = 1'b1;
        if (sel && !wr && held_vec[idx] && (owner_vec[idx] == SIDE))
            rbit = 1'b0;
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank (top)
// A bank of two-port ownership tokens with waiting claims and a left-first
// tie-break.
// Assumes: both ports are synchronous to clk; reset is synchronous and
// active low.
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic             l_wr,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wbit,
    output logic             l_rbit,
    input  logic             r_sel,
    input  logic             r_wr,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wbit,
    output logic             r_rbit
);

    logic [NUM_FLAGS-1:0] claim_l, free_l, claim_r, free_r;
    logic [NUM_FLAGS-1:0] held_vec, owner_vec;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .idx(l_idx), .wbit(l_wbit),
        .claim_vec(claim_l), .free_vec(free_l)
    );

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .idx(r_idx), .wbit(r_wbit),
        .claim_vec(claim_r), .free_vec(free_r)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_cell
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .claim_l(claim_l[k]), .free_l(free_l[k]),
            .claim_r(claim_r[k]), .free_r(free_r[k]),
            .held(held_vec[k]), .owner(owner_vec[k])
        );
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .SIDE(1'b0)) u_rd_l (
        .sel(l_sel), .wr(l_wr), .idx(l_idx),
        .held_vec(held_vec), .owner_vec(owner_vec), .rbit(l_rbit)
    );

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .SIDE(1'b1)) u_rd_r (
        .sel(r_sel), .wr(r_wr), .idx(r_idx),
        .held_vec(held_vec), .owner_vec(owner_vec), .rbit(r_rbit)
    );

endmodule

// File: rtl/sem_bank_chk.sv
// Module: sem_bank_chk
// Checker module holding the temporal properties of sem_bank.
// It is bound to every sem_bank instance.
// Assumes: owner bit 0 means left, 1 means right.
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel,
    input logic                 l_wr,
    input logic [IDX_W-1:0]     l_idx,
    input logic                 l_wbit,
    input logic                 l_rbit,
    input logic                 r_sel,
    input logic                 r_wr,
    input logic [IDX_W-1:0]     r_idx,
    input logic                 r_wbit,
    input logic                 r_rbit,
    input logic [NUM_FLAGS-1:0] held_vec,
    input logic [NUM_FLAGS-1:0] owner_vec
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (held_vec == '0)); // R1

    AST_EXCLUSIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_wr && r_sel && !r_wr && (l_idx == r_idx)) |-> (l_rbit || r_rbit)); // R3

    AST_FREE_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_vec[l_idx] || !held_vec[r_idx]) |->
        ((held_vec[l_idx] || l_rbit) && (held_vec[r_idx] || r_rbit))); // R3

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_prop
        logic lc, lf, rc, rf;
        assign lc = l_sel && l_wr && (l_idx == IDX_W'(k)) && !l_wbit;
        assign lf = l_sel && l_wr && (l_idx == IDX_W'(k)) &&  l_wbit;
        assign rc = r_sel && r_wr && (r_idx == IDX_W'(k)) && !r_wbit;
        assign rf = r_sel && r_wr && (r_idx == IDX_W'(k)) &&  r_wbit;

        AST_LEFT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (!held_vec[k] && lc) |=> (held_vec[k] && !owner_vec[k])); // R8

        AST_RIGHT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (!held_vec[k] && rc && !lc) |=> (held_vec[k] && owner_vec[k])); // R2

        AST_LEFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (held_vec[k] && !owner_vec[k] && !lf) |=> (held_vec[k] && !owner_vec[k])); // R4

        AST_RIGHT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (held_vec[k] && owner_vec[k] && !rf) |=> (held_vec[k] && owner_vec[k])); // R6

        AST_LEFT_LETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (held_vec[k] && !owner_vec[k] && lf) |=> !(held_vec[k] && !owner_vec[k])); // R5

        AST_RIGHT_LETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (held_vec[k] && owner_vec[k] && rf) |=> !(held_vec[k] && owner_vec[k])); // R5
    end

endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wbit(l_wbit), .l_rbit(l_rbit),
    .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wbit(r_wbit), .r_rbit(r_rbit),
    .held_vec(held_vec), .owner_vec(owner_vec)
);

// File: tb/test_sem_bank.sv
// Bench for sem_bank.
// A behavioural reference model is checked against both read bits on
// every clock.
module test_sem_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 1'b0, l_wr = 1'b0, l_wbit = 1'b1;
    logic       r_sel = 1'b0, r_wr = 1'b0, r_wbit = 1'b1;
    logic [2:0] l_idx = '0, r_idx = '0;
    logic       l_rbit, r_rbit;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string tag = "R1";

    // Reference state: holder per token (-1 free, 0 left, 1 right) and waiting claims
    int m_hold [8];
    bit m_wl [8];
    bit m_wr [8];

    always #5 clk = ~clk;

    sem_bank i_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wbit(l_wbit), .l_rbit(l_rbit),
        .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wbit(r_wbit), .r_rbit(r_rbit)
    );

    function automatic bit exp_read(int side, bit sel, bit wr, int idx);
        return !(sel && !wr && m_hold[idx] == side);
    endfunction

    // Advance the model by one clock, using the inputs seen at the edge
    function automatic void model_step();
        for (int k = 0; k < 8; k++) begin
            bit lc = l_sel && l_wr && l_idx == k && !l_wbit;
            bit lf = l_sel && l_wr && l_idx == k &&  l_wbit;
            bit rc = r_sel && r_wr && r_idx == k && !r_wbit;
            bit rf = r_sel && r_wr && r_idx == k &&  r_wbit;
            bit wl = lf ? 0 : ((m_wl[k] || lc) && m_hold[k] != 0);
            bit wr = rf ? 0 : ((m_wr[k] || rc) && m_hold[k] != 1);
            if (m_hold[k] == 0 && lf) m_hold[k] = -1;
            if (m_hold[k] == 1 && rf) m_hold[k] = -1;
            if (m_hold[k] == -1) begin
                if (wl)      begin m_hold[k] = 0; wl = 0; end
                else if (wr) begin m_hold[k] = 1; wr = 0; end
            end
            m_wl[k] = wl;
            m_wr[k] = wr;
        end
    endfunction

    task automatic step(input bit ls, input bit lw, input int li, input bit ld,
                        input bit rs, input bit rw, input int ri, input bit rd);
        bit el, er;
        @(negedge clk);
        l_sel = ls; l_wr = lw; l_idx = 3'(li); l_wbit = ld;
        r_sel = rs; r_wr = rw; r_idx = 3'(ri); r_wbit = rd;
        #1;
        el = exp_read(0, ls, lw, li);
        er = exp_read(1, rs, rw, ri);
        checks++;
        if (l_rbit !== el) begin
            failures++;
            $display("FAIL %s left read idx=%0d actual=%0b expected=%0b", tag, li, l_rbit, el);
        end
        checks++;
        if (r_rbit !== er) begin
            failures++;
            $display("FAIL %s right read idx=%0d actual=%0b expected=%0b", tag, ri, r_rbit, er);
        end
        @(posedge clk);
        #1;
        if (rst_n) model_step();
    endtask

    // Shorthands: idle, left-only access, right-only access, read both
    task automatic idle();  step(0,0,0,1, 0,0,0,1); endtask
    task automatic lw(input int i, input bit d); step(1,1,i,d, 0,0,0,1); endtask
    task automatic rwt(input int i, input bit d); step(0,0,0,1, 1,1,i,d); endtask
    task automatic rd2(input int i); step(1,0,i,1, 1,0,i,1); endtask

    initial begin
        for (int k = 0; k < 8; k++) begin m_hold[k] = -1; m_wl[k] = 0; m_wr[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        tag = "R1";
        for (int k = 0; k < 8; k++) rd2(k);

        tag = "R2";
        lw(2, 0);
        rd2(2);
        tag = "R3";
        step(1,0,3,1, 1,0,2,1);
        step(0,0,2,1, 1,1,2,1);
        tag = "R4";
        rwt(2, 0);
        rd2(2);
        tag = "R7";
        lw(2, 1);
        rd2(2);
        tag = "R6";
        lw(2, 1);
        rd2(2);
        lw(2, 0);
        lw(2, 1);
        rwt(2, 1);
        rd2(2);
        tag = "R5";
        lw(4, 0); lw(4, 1);
        rd2(4);
        tag = "R8";
        step(1,1,5,0, 1,1,5,0);
        rd2(5);
        lw(5, 1);
        rd2(5);
        tag = "R10";
        rwt(5, 0);
        rwt(5, 1);
        rd2(5);
        tag = "R9";
        rwt(0, 0);
        for (int k = 0; k < 8; k++) rd2(k);
        tag = "R11";
        step(0,1,7,0, 0,1,7,0);
        rd2(7);
        step(0,1,0,1, 0,1,0,1);
        rd2(0);

        tag = "R3";
        for (int n = 0; n < 4000; n++)
            step($urandom_range(0,3) != 0, $urandom_range(0,1) == 1, $urandom_range(0,7), $urandom_range(0,1) == 1,
                 $urandom_range(0,3) != 0, $urandom_range(0,1) == 1, $urandom_range(0,7), $urandom_range(0,1) == 1);

        tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 8; k++) begin m_hold[k] = -1; m_wl[k] = 0; m_wr[k] = 0; end
        @(negedge clk) rst_n = 1'b1;
        for (int k = 0; k < 8; k++) rd2(k);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule